// File: doc/BRIEF.md
# Hardware-Timed PID Position Loop with PWM Output

This block closes a position control loop entirely in logic. A free-running sample timer fires once every programmable number of clock cycles. On each firing the block latches the incoming scaled position word, forms the error against a setpoint, and evaluates proportional, integral and derivative terms in signed fixed point with 16 fractional bits. The sum is clamped to the interval 0 to 1 and scaled to a 12-bit duty word, which drives a PWM generator. Because the timer is hardware, the spacing between samples is exactly uniform, which the derivative term relies on.

A host programs the setpoint, the three gains and the sample period through a simple write port. Setpoint and gains sit in shadow registers and are copied to the working set only at a sample boundary, so a half-written set of gains never reaches the arithmetic. Every completed iteration raises an interrupt line that stays high until the host acknowledges it.

Top module: `pid_pwm_loop`

## Requirements
- R1: While reset is asserted and right after it, `duty_word` is 0, `pwm_out` is low and `irq` is low; reset also clears the integrator, the stored previous error, the shadow and working gains and setpoint, and returns the period to its minimum.
- R2: An iteration starts every P clock cycles, where P is the period register (address 4, unsigned, default and minimum 400 cycles, i.e. 100 kHz at a 40 MHz clock); a period write below 400 or not fitting in PERIOD_W bits is ignored.
- R3: Host writes with `host_we` high: address 0 setpoint, 1 proportional gain, 2 integral gain, 3 derivative gain, all signed two's complement with LSB 2^-16; these take effect only from the next sample start.
- R4: The error is setpoint minus position; the proportional term is (Kp*e) arithmetically shifted right by 16.
- R5: The integrator adds (Ki*e)>>>16 once per iteration, saturating at the signed 32-bit range, and the output of that iteration uses the updated integrator.
- R6: The derivative term is (Kd*(e - e_prev))>>>16, where e_prev is the error of the previous iteration (0 after reset).
- R7: The sum u = P + I + D is clamped to [0, 65536] and the duty word is floor(u_clamped*4095/65536), so 1.0 gives 4095.
- R8: Anti-windup: if the previous iteration's unclamped sum exceeded 65536 and e > 0, or was below 0 and e < 0, the integrator keeps its value.
- R9: The PWM frame is 4096 cycles; `pwm_out` is high while the frame counter is below the loaded duty, so a frame holds exactly duty high cycles, and a new duty is loaded only when the counter wraps.
- R10: `irq` rises in the cycle after a sample starts and stays high until `irq_ack`; when a new iteration completes in the same cycle as an acknowledge, `irq` stays high.
- R11: `duty_word` shows the newly computed duty in the same cycle that `irq` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 32 | Host write data |
| pos_sample | input | 32 | Scaled position, signed Q16.16 |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Iteration-complete interrupt |
| duty_word | output | 12 | Duty computed by the last iteration |
| pwm_out | output | 1 | PWM drive |

## Verification
The interrupt set by a finishing iteration and a host acknowledge can land on the same clock edge, and the set must win. The bench holds `irq_ack` high across a sample boundary so that the two coincide, then expects `irq` high for exactly one cycle followed by low. The duty load at a PWM wrap is judged separately by counting high cycles over a full 4096-cycle frame after the duty has settled.

// File: rtl/pidc_pkg.sv
package pidc_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned FRAC_W = 16;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_SETPT  = 3'd0,
    ADDR_KP     = 3'd1,
    ADDR_KI     = 3'd2,
    ADDR_KD     = 3'd3,
    ADDR_PERIOD = 3'd4
  } cfg_addr_e;

  typedef struct packed {
    logic [WORD_W-1:0] setpt;
    logic [WORD_W-1:0] kp;
    logic [WORD_W-1:0] ki;
    logic [WORD_W-1:0] kd;
  } loop_cfg_t;

endpackage

// File: rtl/pidc_tick_gen.sv
module pidc_tick_gen #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // compare with >= so a period lowered mid-count still restarts at once
  always_comb begin
    tick_o = (cnt_q >= (period_i - CNT_W'(1)));
    cnt_d  = tick_o ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // with the period floor in force, two triggers never touch
  assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o)
    else $error("sample triggers on adjacent cycles");

endmodule

// File: rtl/pidc_law.sv
module pidc_law
  import pidc_pkg::*;
#(
  parameter int unsigned DUTY_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  loop_cfg_t         cfg_i,
  input  logic [WORD_W-1:0] pos_i,
  output logic [DUTY_W-1:0] duty_o
);

  localparam int unsigned ACC_W = 2*WORD_W + 4;
  localparam int unsigned ERR_W = WORD_W + 1;
  localparam int unsigned DIF_W = WORD_W + 2;
  localparam int unsigned UCL_W = FRAC_W + 1;
  localparam int unsigned SCL_W = UCL_W + DUTY_W;
  localparam logic signed [ACC_W-1:0] ONE_X =
    {{(ACC_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};
  localparam logic signed [ACC_W-1:0] I_MAX =
    {{(ACC_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] I_MIN =
    {{(ACC_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};
  localparam logic [DUTY_W-1:0] DUTY_MAX = '1;

  function automatic logic signed [ACC_W-1:0] wext(input logic [WORD_W-1:0] v);
    return {{(ACC_W-WORD_W){v[WORD_W-1]}}, v};
  endfunction

  // stored state
  logic signed [WORD_W-1:0] integ_q, integ_d;
  logic signed [ERR_W-1:0]  prev_err_q, prev_err_d;
  logic                     sat_hi_q, sat_hi_d;
  logic                     sat_lo_q, sat_lo_d;
  logic [DUTY_W-1:0]        duty_q, duty_d;

  // datapath
  logic signed [ERR_W-1:0] err;
  logic signed [DIF_W-1:0] diff;
  logic signed [ACC_W-1:0] err_x, diff_x;
  logic signed [ACC_W-1:0] p_term, i_inc, i_sum, i_clip, i_next, d_term, u_sum;
  logic                    hold;
  logic [UCL_W-1:0]        u_cl;
  logic [SCL_W-1:0]        scaled;

  always_comb begin
    err    = $signed({cfg_i.setpt[WORD_W-1], cfg_i.setpt}) -
             $signed({pos_i[WORD_W-1], pos_i});
    diff   = $signed({err[ERR_W-1], err}) -
             $signed({prev_err_q[ERR_W-1], prev_err_q});
    err_x  = {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
    diff_x = {{(ACC_W-DIF_W){diff[DIF_W-1]}}, diff};

    p_term = (wext(cfg_i.kp) * err_x) >>> FRAC_W;
    i_inc  = (wext(cfg_i.ki) * err_x) >>> FRAC_W;
    d_term = (wext(cfg_i.kd) * diff_x) >>> FRAC_W;

    // integrator: saturating add, frozen while pushing further into a rail
    i_sum = wext(integ_q) + i_inc;
    if (i_sum > I_MAX)      i_clip = I_MAX;
    else if (i_sum < I_MIN) i_clip = I_MIN;
    else                    i_clip = i_sum;
    hold   = (sat_hi_q && !err[ERR_W-1] && (err != '0)) ||
             (sat_lo_q && err[ERR_W-1]);
    i_next = hold ? wext(integ_q) : i_clip;

    u_sum  = p_term + i_next + d_term;
    sat_hi_d = (u_sum > ONE_X);
    sat_lo_d = u_sum[ACC_W-1];
    if (sat_hi_d)      u_cl = ONE_X[UCL_W-1:0];
    else if (sat_lo_d) u_cl = '0;
    else               u_cl = u_sum[UCL_W-1:0];
    scaled = {{DUTY_W{1'b0}}, u_cl} * {{UCL_W{1'b0}}, DUTY_MAX};
  end

  // next state, enabled by the sample strobe
  always_comb begin
    integ_d    = integ_q;
    prev_err_d = prev_err_q;
    duty_d     = duty_q;
    if (go_i) begin
      integ_d    = i_next[WORD_W-1:0];
      prev_err_d = err;
      duty_d     = DUTY_W'(scaled >> FRAC_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q    <= '0;
      prev_err_q <= '0;
      sat_hi_q   <= 1'b0;
      sat_lo_q   <= 1'b0;
      duty_q     <= '0;
    end else begin
      integ_q    <= integ_d;
      prev_err_q <= prev_err_d;
      duty_q     <= duty_d;
      if (go_i) begin
        sat_hi_q <= sat_hi_d;
        sat_lo_q <= sat_lo_d;
      end
    end
  end

  assign duty_o = duty_q;

  assert_windup_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && hold) |=> $stable(integ_q))
    else $error("integrator moved while held at a rail");

  assert_full_scale_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && sat_hi_d) |=> (duty_o == DUTY_MAX))
    else $error("upper clamp did not give full duty");

  assert_zero_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && sat_lo_d) |=> (duty_o == '0))
    else $error("lower clamp did not give zero duty");

endmodule

// File: rtl/pidc_pwm.sv
module pidc_pwm #(
  parameter int unsigned DUTY_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);

  logic [DUTY_W-1:0] cnt_q, cnt_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic              wrap;

  always_comb begin
    wrap   = (cnt_q == '1);
    cnt_d  = cnt_q + DUTY_W'(1);
    duty_d = wrap ? duty_i : duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      duty_q <= duty_d;
    end
  end

  assign pwm_o = (cnt_q < duty_q);

  assert_load_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_q) |-> ($past(cnt_q) == '1))
    else $error("duty changed inside a frame");

endmodule

// File: rtl/pid_pwm_loop.sv
module pid_pwm_loop
  import pidc_pkg::*;
#(
  parameter int unsigned PERIOD_W   = 24,
  parameter int unsigned MIN_PERIOD = 400,
  parameter int unsigned DUTY_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic [WORD_W-1:0] pos_sample,
  input  logic              irq_ack,
  output logic              irq,
  output logic [DUTY_W-1:0] duty_word,
  output logic              pwm_out
);

  localparam logic [PERIOD_W-1:0] PERIOD_RST = PERIOD_W'(MIN_PERIOD);

  loop_cfg_t           shadow_q, shadow_d;
  loop_cfg_t           act_q, act_d;
  logic [PERIOD_W-1:0] period_q, period_d;
  logic [WORD_W-1:0]   pos_q, pos_d;
  logic                go_q, irq_q, irq_d;
  logic                tick;
  logic                period_ok;

  pidc_tick_gen #(.CNT_W(PERIOD_W)) i_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_q),
    .tick_o   (tick)
  );

  // host writes land in the shadow set; the period applies at once
  always_comb begin
    shadow_d  = shadow_q;
    period_d  = period_q;
    period_ok = (host_wdata >= WORD_W'(MIN_PERIOD)) &&
                ((host_wdata >> PERIOD_W) == '0);
    if (host_we) begin
      case (host_addr)
        ADDR_SETPT:  shadow_d.setpt = host_wdata;
        ADDR_KP:     shadow_d.kp    = host_wdata;
        ADDR_KI:     shadow_d.ki    = host_wdata;
        ADDR_KD:     shadow_d.kd    = host_wdata;
        ADDR_PERIOD: if (period_ok) period_d = host_wdata[PERIOD_W-1:0];
        default:     ;
      endcase
    end
  end

  // sample boundary: capture position and promote the shadow set
  always_comb begin
    act_d = tick ? shadow_q   : act_q;
    pos_d = tick ? pos_sample : pos_q;
    irq_d = go_q | (irq_q & ~irq_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
      period_q <= PERIOD_RST;
      pos_q    <= '0;
      go_q     <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      act_q    <= act_d;
      period_q <= period_d;
      pos_q    <= pos_d;
      go_q     <= tick;
      irq_q    <= irq_d;
    end
  end

  pidc_law #(.DUTY_W(DUTY_W)) i_law (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (go_q),
    .cfg_i  (act_q),
    .pos_i  (pos_q),
    .duty_o (duty_word)
  );

  pidc_pwm #(.DUTY_W(DUTY_W)) i_pwm (
    .clk    (clk),
    .rst_n  (rst_n),
    .duty_i (duty_word),
    .pwm_o  (pwm_out)
  );

  assign irq = irq_q;

  assert_period_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_q >= PERIOD_RST)
    else $error("period below conversion limit");

  assert_active_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(act_q))
    else $error("working gains changed between samples");

  assert_irq_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> irq)
    else $error("finished iteration did not raise irq");

  assert_irq_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_ack && !go_q) |=> !irq)
    else $error("acknowledge did not clear irq");

endmodule

// File: tb/test_pid_pwm_loop.sv
module test_pid_pwm_loop;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] pos_sample = '0;
  logic        irq_ack = 1'b0;
  logic        irq;
  logic [11:0] duty_word;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pid_pwm_loop i_pid_pwm_loop (
    .clk (clk), .rst_n (rst_n), .host_we (host_we), .host_addr (host_addr),
    .host_wdata (host_wdata), .pos_sample (pos_sample), .irq_ack (irq_ack),
    .irq (irq), .duty_word (duty_word), .pwm_out (pwm_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=%0d expected=finish", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // {setpoint, position, kp, expected duty}
  localparam logic [127:0] VECS [8] = '{
    {32'h0000_8000, 32'h0000_0000, 32'h0001_0000, 32'd2047},
    {32'h0001_0000, 32'h0000_4000, 32'h0002_0000, 32'd4095},
    {32'h0000_2000, 32'h0000_6000, 32'h0001_0000, 32'd0},
    {32'h0001_0000, 32'h0000_8000, 32'h0000_8000, 32'd1023},
    {32'h0000_0003, 32'h0000_0000, 32'h0001_0000, 32'd0},
    {32'h0001_0000, 32'h0000_0000, 32'h0001_0000, 32'd4095},
    {32'h0000_0000, 32'hFFFF_C000, 32'h0003_0000, 32'd3071},
    {32'h0000_0000, 32'h0000_8000, 32'hFFFF_0000, 32'd2047}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // clear any stale interrupt, wait for a fresh one, acknowledge it
  task automatic wait_irq(output int t, output int d);
    if (irq) begin
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    end
    @(negedge clk);
    while (!irq) @(negedge clk);
    t = cyc;
    d = duty_word;
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 duty in reset", duty_word, 0);
    chk("R1 pwm in reset", pwm_out, 0);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
  endtask

  function automatic int exp_duty(input longint u);
    longint c;
    c = (u < 0) ? 0 : ((u > 65536) ? 65536 : u);
    return int'((c * 4095) >>> 16);
  endfunction

  initial begin
    int t0, t1, d0, hi;
    repeat (4) @(negedge clk);
    do_reset();

    // R4/R7 proportional vectors, walked by one loop; R9 high-count on some
    for (int i = 0; i < 8; i++) begin
      wait_irq(t0, d0);
      wr(3'd0, VECS[i][127:96]);
      wr(3'd1, VECS[i][63:32]);
      pos_sample = VECS[i][95:64];
      wait_irq(t0, d0);
      chk($sformatf("R4 R7 vector %0d", i), d0, longint'(VECS[i][31:0]));
      if (i == 2 || i == 3 || i == 5) begin
        repeat (8200) @(negedge clk);
        hi = 0;
        for (int k = 0; k < 4096; k++) begin
          @(negedge clk);
          if (pwm_out) hi++;
        end
        chk($sformatf("R9 high cycles vector %0d", i), hi, longint'(VECS[i][31:0]));
      end
    end

    // R1 reset after activity; R6 derivative kick then zero
    pos_sample = '0;
    do_reset();
    chk("R1 duty after reset", duty_word, 0);
    wait_irq(t0, d0);
    chk("R1 first sample duty", d0, 0);
    wr(3'd0, 32'h0000_8000);
    wr(3'd3, 32'h0001_0000);
    wait_irq(t0, d0);
    chk("R6 derivative kick", d0, 2047);
    wait_irq(t0, d0);
    chk("R6 derivative settles", d0, 0);

    // R5 integral ramp, R8 anti-windup unwinding
    do_reset();
    wait_irq(t0, d0);
    wr(3'd2, 32'h0000_4000);
    wr(3'd0, 32'h0000_2000);
    for (int n = 1; n <= 40; n++) begin
      longint u;
      wait_irq(t0, d0);
      u = (n <= 33) ? 2048 * n : 67584;
      chk($sformatf("R5 integral step %0d", n), d0, exp_duty(u));
    end
    wr(3'd0, 32'hFFFF_E000);
    wait_irq(t0, d0);
    chk("R8 unwind step 1", d0, 4095);
    wait_irq(t0, d0);
    chk("R8 unwind step 2", d0, 3967);

    // R2 period: default, refused short value, refused wide value, accepted value
    do_reset();
    wait_irq(t0, d0);
    wait_irq(t1, d0);
    chk("R2 default period", t1 - t0, 400);
    wr(3'd4, 32'd399);
    wait_irq(t0, d0);
    wait_irq(t0, d0);
    wait_irq(t1, d0);
    chk("R2 short period refused", t1 - t0, 400);
    wr(3'd4, 32'd523);
    wait_irq(t0, d0);
    wait_irq(t0, d0);
    wait_irq(t1, d0);
    chk("R2 period 523", t1 - t0, 523);
    wr(3'd4, 32'h0100_0000);
    wait_irq(t0, d0);
    wait_irq(t0, d0);
    wait_irq(t1, d0);
    chk("R2 wide period refused", t1 - t0, 523);

    // R10/R11: completion and acknowledge on the same edge
    wr(3'd0, 32'h0000_8000);
    wr(3'd1, 32'h0001_0000);
    wait_irq(t0, d0);
    irq_ack = 1'b1;
    @(negedge clk);
    while (!irq) @(negedge clk);
    chk("R10 set wins over ack", irq, 1);
    chk("R11 duty with irq", duty_word, 2047);
    @(negedge clk);
    chk("R10 ack clears next cycle", irq, 0);
    irq_ack = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule